// File: doc/BRIEF.md
# Dual-Channel PLL Lock Detector with Unlock Stretching

This block watches the phase-error pulses of two PLL channels, A and B. It decides for each channel whether the loop is locked. A channel is judged to have an unlock event when its phase-error pulse stays high longer than a selectable threshold, counted in system clock cycles. It also has an unlock event when the divider or mode configuration is rewritten. An unlock event raises the channel's unlock indicator. That indicator can be held for a programmable number of reference periods, so that a brief loss of lock stays visible to slower logic. One mode instead copies the raw error pulse to the output with no stretching.

Each channel also drives a locked flag. The flag falls on any unlock event. It rises again only after a whole reference period passes with no event. Channel B can be stopped, either by single-loop operation or by standby. While it is stopped, its outputs are held inactive and its state is cleared. The reference-period tick and the phase-error pulses come from logic outside this block.

Top module: `lock_watch`

## Requirements
- R1: While rst_ni is low, all four outputs are 0.
- R2: Threshold select thr_sel_i values 0, 1, 2 and 3 set a limit T of 2, 4, 8 and 16 clock cycles. A phase-error pulse is an unlock event on the clock where it has been high for more than T consecutive cycles. It remains an event on every further clock while it stays high.
- R3: With ext_sel_i = 0 (raw mode), the unlock output equals the OR of that channel's phase-error input and cfg_chg_i, delayed by one clock.
- R4: With ext_sel_i = 1, 2 or 3, an unlock event raises the unlock output on the next clock. The output then falls on the clock after the 4th, 16th or 64th ref_tick_i pulse that follows the last event.
- R5: An event that arrives while an extension is running restarts the full extension count.
- R6: The locked flag falls on the clock after any unlock event. It rises on the clock after a ref_tick_i only if a previous tick occurred since reset or reactivation, and no event occurred between the two ticks or on the tick itself.
- R7: A cfg_chg_i pulse counts as an unlock event on both active channels in every mode. It raises both unlock outputs and clears both locked flags on the next clock.
- R8: While dual_en_i is 0 or standby_i is 1, unlock_b_o and locked_b_o are 0 and channel B's state is cleared. When channel B is reactivated, it starts again from its reset state.
- R9: The two channels are independent. Phase errors on one channel never change the other channel's outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | One-cycle pulse per reference period |
| perr_a_i | input | 1 | Channel A phase-error pulse |
| perr_b_i | input | 1 | Channel B phase-error pulse |
| thr_sel_i | input | 2 | Phase-error width threshold select |
| ext_sel_i | input | 2 | Unlock extension select (0 = raw) |
| dual_en_i | input | 1 | Channel B running when 1 |
| standby_i | input | 1 | Standby, stops channel B when 1 |
| cfg_chg_i | input | 1 | Configuration rewrite strobe |
| unlock_a_o | output | 1 | Channel A unlock indicator |
| unlock_b_o | output | 1 | Channel B unlock indicator |
| locked_a_o | output | 1 | Channel A locked flag |
| locked_b_o | output | 1 | Channel B locked flag |

## Verification
The case that needs care is an over-threshold event that falls in the same clock as a reference tick. Both the extension counter and the period-clean tracker then see a decrement or close-of-period and a new event together, and in each case the event must win. The bench raises this collision often. It runs dense, randomly toggled error pulses against a tick that repeats every five cycles, across all sixteen threshold and extension settings. Every output is compared on every cycle with an arithmetic model that counts ticks since the last event and tracks events per period.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
  typedef enum logic [1:0] {
    EXT_RAW   = 2'd0,
    EXT_SHORT = 2'd1,
    EXT_MID   = 2'd2,
    EXT_LONG  = 2'd3
  } ext_mode_e;
endpackage

// File: rtl/lockdet_width.sv
module lockdet_width #(
  parameter int unsigned CW  = 5,
  parameter int unsigned SAT = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          perr_i,
  input  logic [CW-1:0] thr_i,
  output logic          over_o
);
  logic [CW-1:0] run_q;

  // consecutive high cycles seen before the current one, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (clr_i || !perr_i) run_q <= '0;
    else if (run_q != CW'(SAT)) run_q <= run_q + CW'(1);
  end

  assign over_o = perr_i && !clr_i && (run_q >= thr_i);
endmodule

// File: rtl/lockdet_stretch.sv
module lockdet_stretch
  import lockdet_pkg::*;
#(
  parameter int unsigned EW = 7,
  parameter int unsigned E1 = 4,
  parameter int unsigned E2 = 16,
  parameter int unsigned E3 = 64
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      tick_i,
  input  logic      hit_i,
  input  logic      raw_i,
  input  ext_mode_e mode_i,
  output logic      unlock_o,
  output logic      locked_o
);
  logic [EW-1:0] len, cnt_q;
  logic          raw_q, clean_q, lock_q;

  always_comb begin
    case (mode_i)
      EXT_SHORT: len = EW'(E1);
      EXT_MID:   len = EW'(E2);
      EXT_LONG:  len = EW'(E3);
      default:   len = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      raw_q   <= 1'b0;
      clean_q <= 1'b0;
      lock_q  <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      raw_q   <= 1'b0;
      clean_q <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      raw_q <= raw_i;
      // a fresh event reloads the full extension, beating a tick
      if (hit_i) cnt_q <= len;
      else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - EW'(1);
      // clean_q: a period boundary has passed and no event since it
      if (tick_i) begin
        lock_q  <= clean_q & ~hit_i;
        clean_q <= 1'b1;
      end else if (hit_i) begin
        lock_q  <= 1'b0;
        clean_q <= 1'b0;
      end
    end
  end

  assign unlock_o = (mode_i == EXT_RAW) ? raw_q : (cnt_q != '0);
  assign locked_o = lock_q;
endmodule

// File: rtl/lock_watch.sv
module lock_watch
  import lockdet_pkg::*;
#(
  parameter int unsigned THR0 = 2,
  parameter int unsigned THR1 = 4,
  parameter int unsigned THR2 = 8,
  parameter int unsigned THR3 = 16,
  parameter int unsigned EXT1 = 4,
  parameter int unsigned EXT2 = 16,
  parameter int unsigned EXT3 = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_tick_i,
  input  logic       perr_a_i,
  input  logic       perr_b_i,
  input  logic [1:0] thr_sel_i,
  input  logic [1:0] ext_sel_i,
  input  logic       dual_en_i,
  input  logic       standby_i,
  input  logic       cfg_chg_i,
  output logic       unlock_a_o,
  output logic       unlock_b_o,
  output logic       locked_a_o,
  output logic       locked_b_o
);
  localparam int unsigned NCH     = 2;
  localparam int unsigned THR_MAX = (THR3 > THR2) ? ((THR3 > THR1) ? ((THR3 > THR0) ? THR3 : THR0) : THR1)
                                                  : ((THR2 > THR1) ? ((THR2 > THR0) ? THR2 : THR0) : THR1);
  localparam int unsigned CW      = $clog2(THR_MAX + 1);
  localparam int unsigned EW      = $clog2(EXT3 + 1);

  logic [CW-1:0] thr_cyc;
  logic          b_active;
  logic [NCH-1:0] perr, clr, over, hit, unl, lck;
  ext_mode_e     mode;

  always_comb begin
    case (thr_sel_i)
      2'd0:    thr_cyc = CW'(THR0);
      2'd1:    thr_cyc = CW'(THR1);
      2'd2:    thr_cyc = CW'(THR2);
      default: thr_cyc = CW'(THR3);
    endcase
  end

  assign mode     = ext_mode_e'(ext_sel_i);
  assign b_active = dual_en_i & ~standby_i;
  assign perr     = {perr_b_i, perr_a_i};
  assign clr      = {~b_active, 1'b0};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    lockdet_width #(.CW(CW), .SAT(THR_MAX)) u_width (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr[c]),
      .perr_i (perr[c]),
      .thr_i  (thr_cyc),
      .over_o (over[c])
    );

    assign hit[c] = over[c] | (cfg_chg_i & ~clr[c]);

    lockdet_stretch #(.EW(EW), .E1(EXT1), .E2(EXT2), .E3(EXT3)) u_stretch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr[c]),
      .tick_i   (ref_tick_i),
      .hit_i    (hit[c]),
      .raw_i    (perr[c] | cfg_chg_i),
      .mode_i   (mode),
      .unlock_o (unl[c]),
      .locked_o (lck[c])
    );
  end

  assign unlock_a_o = unl[0];
  assign locked_a_o = lck[0];
  assign unlock_b_o = unl[1] & b_active;
  assign locked_b_o = lck[1] & b_active;
endmodule

// File: rtl/lock_watch_chk.sv
module lock_watch_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ref_tick_i,
  input logic       perr_a_i,
  input logic       perr_b_i,
  input logic [1:0] thr_sel_i,
  input logic [1:0] ext_sel_i,
  input logic       dual_en_i,
  input logic       standby_i,
  input logic       cfg_chg_i,
  input logic       unlock_a_o,
  input logic       unlock_b_o,
  input logic       locked_a_o,
  input logic       locked_b_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else armed_q <= 1'b1;
  end

  AST_B_STOPPED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dual_en_i || standby_i) |-> (!unlock_b_o && !locked_b_o)); // R8

  AST_RAW_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && ext_sel_i == 2'd0 && $stable(ext_sel_i))
      |-> (unlock_a_o == $past(perr_a_i | cfg_chg_i))); // R3

  AST_CFG_FORCES_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(cfg_chg_i) && $stable(ext_sel_i))
      |-> (unlock_a_o && !locked_a_o)); // R7

  AST_LOCK_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $rose(locked_a_o)) |-> $past(ref_tick_i)); // R6

  AST_EXT_ENDS_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && ext_sel_i != 2'd0 && $stable(ext_sel_i) && $fell(unlock_a_o))
      |-> $past(ref_tick_i)); // R4

  AST_NO_B_UNLOCK_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $rose(unlock_b_o)) |-> (dual_en_i && !standby_i)); // R8
endmodule

bind lock_watch lock_watch_chk u_chk (.*);

// File: tb/lock_watch_test.sv
module lock_watch_test;
  localparam int TP = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       perr_a = 1'b0, perr_b = 1'b0;
  logic [1:0] thr_sel = 2'd0, ext_sel = 2'd0;
  logic       dual_en = 1'b1, standby = 1'b0, cfg_chg = 1'b0;
  logic       unlock_a, unlock_b, locked_a, locked_b;

  int vecs = 0, errs = 0, tcnt = 0;
  bit cmp_en = 1'b0, done = 1'b0;
  string utag = "R4";
  logic [15:0] lf = 16'hace1;

  int thr_tab[4] = '{2, 4, 8, 16};
  int len_tab[4] = '{0, 4, 16, 64};

  always #2 clk = ~clk;

  lock_watch uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick),
    .perr_a_i(perr_a), .perr_b_i(perr_b),
    .thr_sel_i(thr_sel), .ext_sel_i(ext_sel),
    .dual_en_i(dual_en), .standby_i(standby), .cfg_chg_i(cfg_chg),
    .unlock_a_o(unlock_a), .unlock_b_o(unlock_b),
    .locked_a_o(locked_a), .locked_b_o(locked_b)
  );

  // arithmetic reference: ticks since last event, per-period event record
  int m_run[2], m_ticks[2];
  bit m_have[2], m_clean[2], m_lock[2], m_raw[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_run[c] = 0; m_ticks[c] = 0; m_have[c] = 0;
        m_clean[c] = 0; m_lock[c] = 0; m_raw[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit p, act, ev;
        p   = (c == 0) ? perr_a : perr_b;
        act = (c == 0) || (dual_en && !standby);
        if (!act) begin
          m_run[c] = 0; m_ticks[c] = 0; m_have[c] = 0;
          m_clean[c] = 0; m_lock[c] = 0; m_raw[c] = 0;
        end else begin
          ev = (p && m_run[c] >= thr_tab[thr_sel]) || cfg_chg;
          m_run[c] = p ? ((m_run[c] < 100) ? m_run[c] + 1 : 100) : 0;
          m_raw[c] = p | cfg_chg;
          if (ev) begin m_have[c] = 1; m_ticks[c] = 0; end
          else if (ref_tick && m_ticks[c] < 1000) m_ticks[c]++;
          if (ref_tick) begin m_lock[c] = m_clean[c] && !ev; m_clean[c] = 1; end
          else if (ev) begin m_lock[c] = 0; m_clean[c] = 0; end
        end
      end
    end
  end

  function automatic bit exp_unl(int c);
    if (ext_sel == 2'd0) return m_raw[c];
    return m_have[c] && (m_ticks[c] < len_tab[ext_sel]);
  endfunction

  task automatic chk(string tag, string what, logic got, logic exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit bact;
    bact = dual_en && !standby;
    if (cmp_en) begin
      chk(utag, "unlock_a", unlock_a, exp_unl(0));
      chk(bact ? utag : "R8", "unlock_b", unlock_b, bact && exp_unl(1));
      chk("R6", "locked_a", locked_a, m_lock[0]);
      chk(bact ? "R6" : "R8", "locked_b", locked_b, bact && m_lock[1]);
    end
  endtask

  task automatic tc();
    @(negedge clk);
    compare_all();
    tcnt = (tcnt + 1) % TP;
    ref_tick = (tcnt == 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmp_en = 1'b0;
    perr_a = 0; perr_b = 0; cfg_chg = 0; ref_tick = 0;
    repeat (2) @(negedge clk);
    chk("R1", "unlock_a in reset", unlock_a, 1'b0);
    chk("R1", "unlock_b in reset", unlock_b, 1'b0);
    chk("R1", "locked_a in reset", locked_a, 1'b0);
    chk("R1", "locked_b in reset", locked_b, 1'b0);
    rst_n = 1'b1; cmp_en = 1'b1; tcnt = 0;
  endtask

  task automatic rnd();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    // R2 width sweep; R9: channel B must stay quiet
    utag = "R2";
    for (int s = 0; s < 4; s++) begin
      for (int w = 1; w <= 20; w++) begin
        bit seen_a, seen_b;
        thr_sel = 2'(s); ext_sel = 2'd1; dual_en = 1; standby = 0;
        do_reset();
        repeat (3) tc();
        seen_a = 0; seen_b = 0;
        perr_a = 1;
        for (int k = 0; k < w + 3; k++) begin
          if (k == w) perr_a = 0;
          tc();
          seen_a |= unlock_a;
          seen_b |= unlock_b;
        end
        chk("R2", $sformatf("event thr%0d width%0d", s, w), seen_a, 1'(w > thr_tab[s]));
        chk("R9", "channel B untouched", seen_b, 1'b0);
      end
    end

    // R5 restart of the extension
    utag = "R5"; thr_sel = 0; ext_sel = 1;
    do_reset();
    repeat (3) tc();
    perr_a = 1; repeat (4) tc(); perr_a = 0;
    repeat (12) tc();
    perr_a = 1; repeat (4) tc(); perr_a = 0;
    repeat (8) tc();
    chk("R5", "held by restarted extension", unlock_a, 1'b1);
    repeat (25) tc();
    chk("R5", "released after full extension", unlock_a, 1'b0);

    // R7 configuration rewrite, stretched and raw modes
    for (int e = 2; e >= 0; e -= 2) begin
      utag = "R7"; thr_sel = 3; ext_sel = 2'(e);
      do_reset();
      repeat (20) tc();
      chk("R6", "A locked when quiet", locked_a, 1'b1);
      chk("R6", "B locked when quiet", locked_b, 1'b1);
      cfg_chg = 1; tc(); cfg_chg = 0;
      chk("R7", "unlock_a after rewrite", unlock_a, 1'b1);
      chk("R7", "unlock_b after rewrite", unlock_b, 1'b1);
      chk("R7", "locked_a after rewrite", locked_a, 1'b0);
      chk("R7", "locked_b after rewrite", locked_b, 1'b0);
      tc();
      if (e == 0) chk("R3", "raw unlock_a drops", unlock_a, 1'b0);
    end

    // R8 channel B stop and restart
    utag = "R8"; thr_sel = 0; ext_sel = 1;
    do_reset();
    repeat (20) tc();
    standby = 1; perr_b = 1;
    repeat (6) tc();
    chk("R8", "unlock_b in standby", unlock_b, 1'b0);
    chk("R8", "locked_b in standby", locked_b, 1'b0);
    standby = 0; perr_b = 0;
    tc();
    chk("R8", "locked_b restarts clear", locked_b, 1'b0);
    chk("R9", "locked_a unaffected by B", locked_a, 1'b1);

    // random sweep over all threshold and extension settings
    for (int t = 0; t < 4; t++) begin
      for (int e = 0; e < 4; e++) begin
        thr_sel = 2'(t); ext_sel = 2'(e); dual_en = 1; standby = 0;
        utag = (e == 0) ? "R3" : "R4";
        do_reset();
        for (int i = 0; i < 800; i++) begin
          if (i < 400) begin
            rnd();
            if (lf[2:0] == 3'd0) perr_a = ~perr_a;
            if (lf[5:3] == 3'd0) perr_b = ~perr_b;
            if (lf[11:6] == 6'd0) dual_en = ~dual_en;
            if (lf[15:10] == 6'd1) standby = ~standby;
            cfg_chg = (lf[15:9] == 7'h5a);
          end else begin
            perr_a = 0; perr_b = 0; cfg_chg = 0; dual_en = 1; standby = 0;
          end
          tc();
        end
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule